// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This block lets several processors pass short fixed-length messages to one another and raise interrupts on each other. It is reached through a simple register bus with an address, write data, and separate write and read strobes. Each channel has its own register window holding ownership, target, mask, pending, mode and message words. The block drives one interrupt line per vector bit. Each line is the OR, across all channels, of that channel's pending and unmasked bits.

A sender claims a free channel by writing its own one-hot vector bit into the ownership register. It then reads that register back to confirm the claim. Next it picks the target lines, unmasks them, fills the message words and writes its bit to the trigger register. In self-acknowledge mode the channel drops back out of busy by itself one cycle later. In manual mode it waits for the receiver to write the target-clear register. The sender then releases the channel by writing its bit to the ownership register again. Every channel write is blocked by a global lock that only a fixed key value opens.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the lock reads 1 (locked), every channel is unowned with ownership 0, target 0, mask all ones and manual mode, its state register reads 0x10, and `irq_o` is 0.
- R2: A write of 0x1ACCE551 to byte address 0xA00 opens the lock, which then reads 0. Any other value written there closes it again, and it reads 1. While the lock is closed, writes to any channel register have no effect.
- R3: Channel c occupies byte addresses c*0x40 to c*0x40+0x3F. The word offsets are: 0x00 ownership, 0x04 target, 0x08 target clear, 0x0C pending status, 0x10 mode/state, 0x14 mask, 0x18 pending clear, 0x1C trigger, and 0x20 to 0x3C message words 0 to 7. The clear, trigger and unmapped locations read 0.
- R4: A write to the ownership register of an unowned, idle channel takes effect only when the value is one-hot. A write that shares no bit with the current owner leaves ownership unchanged. This covers a busy channel or one claimed by another sender. Ownership never holds more than one bit.
- R5: A write to the ownership register of a non-busy channel that shares a bit with the current owner releases it. Ownership then reads 0 and the state returns to idle.
- R6: In the mode/state register, bit 0 is the self-acknowledge mode bit (written and read), bit 4 reads 1 when idle, and bit 7 reads 1 when acknowledged.
- R7: A trigger write that shares a bit with the owner of an idle channel ORs the target vector into the channel's pending bits and makes the channel busy. A trigger write on an unowned or non-idle channel is ignored.
- R8: The pending status register reads the pending bits with masked bits cleared. `irq_o` bit k is 1 when any channel has bit k pending and unmasked.
- R9: A write to the pending clear register clears every pending bit written as 1 and leaves the others.
- R10: In self-acknowledge mode a busy channel becomes acknowledged on the next clock edge.
- R11: In manual mode a busy channel stays busy until a target-clear write, which makes it acknowledged. The target-clear write also clears the target bits written as 1.
- R12: `rdata_o` presents the addressed register one cycle after `rd_i`. Message words read back as written, and addresses outside the channel windows and the lock read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 32 | Interrupt lines, one per vector bit |

## Verification
A wrong channel state shows up on the next read of the mode/state register: the idle and acknowledge bits expose it directly. A lost or stray pending bit reaches `irq_o` in the same cycle as the edge that caused it, and it reaches the pending status register at the next read. A lock or ownership fault becomes visible one read later: the ownership or target register keeps a value it should not hold. Because of this, each directed step is followed by a read-back of the register it could have disturbed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WIN_SHIFT = 6;  // 0x40-byte channel window
  localparam int unsigned IDLE_BIT  = 4;
  localparam int unsigned ACK_BIT   = 7;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  // word offsets inside a channel window
  localparam logic [3:0] OFF_SRC   = 4'd0;
  localparam logic [3:0] OFF_DST   = 4'd1;
  localparam logic [3:0] OFF_DCLR  = 4'd2;
  localparam logic [3:0] OFF_DSTAT = 4'd3;
  localparam logic [3:0] OFF_MODE  = 4'd4;
  localparam logic [3:0] OFF_MASK  = 4'd5;
  localparam logic [3:0] OFF_ICLR  = 4'd6;
  localparam logic [3:0] OFF_SEND  = 4'd7;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_BUSY  = 2'd1,
    CH_ACKED = 2'd2
  } ch_state_e;
endpackage

// File: rtl/mbox_lock.sv
module mbox_lock #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] KEY = mbox_pkg::UNLOCK_KEY
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_q <= 1'b1;
    else if (wr_i) locked_q <= (wdata_i != KEY);
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned MSG_WORDS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [3:0]    off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] irq_vec_o,
  output logic [DW-1:0] src_o,
  output logic          idle_o,
  output logic          ack_o,
  output logic          auto_o
);
  localparam int unsigned MSG_AW = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;

  ch_state_e                   st_q;
  logic [DW-1:0]               src_q, dst_q, mask_q, pend_q;
  logic                        auto_q;
  logic [MSG_WORDS-1:0][DW-1:0] msg_q;

  logic          src_hit, wr_onehot, is_msg;
  logic [2:0]    msg_idx;

  assign src_hit   = |(wdata_i & src_q);
  assign wr_onehot = (wdata_i != '0) && ((wdata_i & (wdata_i - 1'b1)) == '0);
  assign msg_idx   = off_i[2:0];
  assign is_msg    = off_i[3] && (32'(msg_idx) < MSG_WORDS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
      auto_q <= 1'b0;
      msg_q  <= '0;
    end else begin
      if (st_q == CH_BUSY && auto_q) st_q <= CH_ACKED;
      if (wr_i) begin
        unique case (off_i)
          OFF_SRC: begin
            if (st_q != CH_BUSY && src_hit) begin
              src_q <= '0;
              st_q  <= CH_IDLE;
            end else if (src_q == '0 && st_q == CH_IDLE && wr_onehot) begin
              src_q <= wdata_i;
            end
          end
          OFF_DST:  dst_q <= wdata_i;
          OFF_DCLR: begin
            dst_q <= dst_q & ~wdata_i;
            if (st_q == CH_BUSY && !auto_q) st_q <= CH_ACKED;
          end
          OFF_MODE: auto_q <= wdata_i[0];
          OFF_MASK: mask_q <= wdata_i;
          OFF_ICLR: pend_q <= pend_q & ~wdata_i;
          OFF_SEND: begin
            if (st_q == CH_IDLE && src_hit) begin
              pend_q <= pend_q | dst_q;
              st_q   <= CH_BUSY;
            end
          end
          default: if (is_msg) msg_q[MSG_AW'(msg_idx)] <= wdata_i;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      OFF_SRC:   rdata_o = src_q;
      OFF_DST:   rdata_o = dst_q;
      OFF_DSTAT: rdata_o = pend_q & ~mask_q;
      OFF_MODE: begin
        rdata_o[0]        = auto_q;
        rdata_o[IDLE_BIT] = (st_q == CH_IDLE);
        rdata_o[ACK_BIT]  = (st_q == CH_ACKED);
      end
      OFF_MASK:  rdata_o = mask_q;
      default:   if (is_msg) rdata_o = msg_q[MSG_AW'(msg_idx)];
    endcase
  end

  assign irq_vec_o = pend_q & ~mask_q;
  assign src_o     = src_q;
  assign idle_o    = (st_q == CH_IDLE);
  assign ack_o     = (st_q == CH_ACKED);
  assign auto_o    = auto_q;
endmodule

// File: rtl/mbox_irq_merge.sv
module mbox_irq_merge #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DW     = 32
) (
  input  logic [NUM_CH-1:0][DW-1:0] vec_i,
  output logic [DW-1:0]             irq_o
);
  always_comb begin
    irq_o = '0;
    for (int c = 0; c < NUM_CH; c++) irq_o |= vec_i[c];
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LOCK_ADDR = 32'hA00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     irq_o
);
  localparam int unsigned CH_AW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W:0] CH_SPAN = (ADDR_W+1)'(NUM_CH << WIN_SHIFT);

  logic                      lock_q;
  logic                      in_win, lock_hit;
  logic [CH_AW-1:0]          ch_idx;
  logic [3:0]                off;
  logic [NUM_CH-1:0]         ch_sel;
  logic [NUM_CH-1:0][DW-1:0] ch_rdata, ch_irq, ch_src;
  logic [NUM_CH-1:0]         ch_idle, ch_ack, ch_auto;
  logic [DW-1:0]             rd_mux, rdata_q;

  assign in_win   = {1'b0, addr_i} < CH_SPAN;
  assign lock_hit = (32'(addr_i) == LOCK_ADDR);
  assign ch_idx   = addr_i[WIN_SHIFT +: CH_AW];
  assign off      = addr_i[5:2];

  mbox_lock #(.DW(DW)) i_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i && lock_hit),
    .wdata_i  (wdata_i),
    .locked_o (lock_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_sel[c] = in_win && (32'(ch_idx) == c);
    mbox_chan #(.DW(DW), .MSG_WORDS(MSG_WORDS)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i && ch_sel[c] && !lock_q),
      .off_i     (off),
      .wdata_i   (wdata_i),
      .rdata_o   (ch_rdata[c]),
      .irq_vec_o (ch_irq[c]),
      .src_o     (ch_src[c]),
      .idle_o    (ch_idle[c]),
      .ack_o     (ch_ack[c]),
      .auto_o    (ch_auto[c])
    );
  end

  mbox_irq_merge #(.NUM_CH(NUM_CH), .DW(DW)) i_irq (
    .vec_i (ch_irq),
    .irq_o (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) if (ch_sel[c]) rd_mux = ch_rdata[c];
    if (lock_hit) rd_mux = DW'(lock_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LOCK_ADDR = 32'hA00
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DW-1:0]             wdata_i,
  input logic                      wr_i,
  input logic                      rd_i,
  input logic [DW-1:0]             rdata_o,
  input logic                      lock_i,
  input logic [NUM_CH-1:0][DW-1:0] src_i,
  input logic [NUM_CH-1:0]         idle_i,
  input logic [NUM_CH-1:0]         ack_i,
  input logic [NUM_CH-1:0]         auto_i
);
  localparam int unsigned CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic chan_addr;
  logic [3:0] woff;
  assign chan_addr = (32'(addr_i) < (NUM_CH << WIN_SHIFT));
  assign woff      = addr_i[5:2];

  AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && wr_i && chan_addr) |=> ($stable(src_i) && $stable(auto_i)))
    else $error("locked write changed channel state"); // R2

  AST_LOCK_READ_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !lock_i && 32'(addr_i) == LOCK_ADDR) |=> (rdata_o == '0))
    else $error("open lock did not read zero"); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic hit;
    assign hit = wr_i && !lock_i && chan_addr && (32'(addr_i[WIN_SHIFT +: CH_AW]) == c);

    AST_SRC_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(src_i[c]))
      else $error("ownership holds several bits"); // R4

    AST_CLAIM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && woff == OFF_SRC && src_i[c] != '0 && (wdata_i & src_i[c]) == '0)
      |=> $stable(src_i[c]))
      else $error("foreign claim took an owned channel"); // R4

    AST_AUTO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!idle_i[c] && !ack_i[c] && auto_i[c]) |=> ack_i[c])
      else $error("self-acknowledge missed"); // R10

    AST_MANUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!idle_i[c] && !ack_i[c] && !auto_i[c] && !(hit && woff == OFF_DCLR))
      |=> (!idle_i[c] && !ack_i[c]))
      else $error("manual channel left busy early"); // R11
  end
endmodule

bind mbox_ctrl mbox_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)
) i_mbox_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .lock_i  (lock_q),
  .src_i   (ch_src),
  .idle_i  (ch_idle),
  .ack_i   (ch_ack),
  .auto_i  (ch_auto)
);

// File: tb/test_mbox_ctrl.sv
`timescale 1ns/1ps
module test_mbox_ctrl;
  localparam time CLK_P = 4ns;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // channel 1 lives at 0x40
  localparam vec_t TBL [25] = '{
    '{1'b0, 12'hA00, 32'h0, 32'h1, 8'd1},               // R1 lock reads 1
    '{1'b1, 12'h040, 32'h4, 32'h0, 8'd2},               // R2 write while locked
    '{1'b0, 12'h040, 32'h0, 32'h0, 8'd2},               // R2 ignored
    '{1'b1, 12'hA00, 32'h1ACCE551, 32'h0, 8'd2},
    '{1'b0, 12'hA00, 32'h0, 32'h0, 8'd2},               // R2 open reads 0
    '{1'b1, 12'h040, 32'h4, 32'h0, 8'd4},               // claim
    '{1'b0, 12'h040, 32'h0, 32'h4, 8'd4},               // R4
    '{1'b1, 12'h040, 32'h8, 32'h0, 8'd4},               // foreign claim
    '{1'b0, 12'h040, 32'h0, 32'h4, 8'd4},               // R4 unchanged
    '{1'b1, 12'h044, 32'h10, 32'h0, 8'd3},
    '{1'b1, 12'h054, 32'hFFFF_FFEF, 32'h0, 8'd3},
    '{1'b1, 12'h050, 32'h1, 32'h0, 8'd6},
    '{1'b0, 12'h050, 32'h0, 32'h11, 8'd6},              // R6 auto+idle
    '{1'b1, 12'h060, 32'hDEAD_BEEF, 32'h0, 8'd12},
    '{1'b1, 12'h07C, 32'h1234_5678, 32'h0, 8'd12},
    '{1'b0, 12'h060, 32'h0, 32'hDEAD_BEEF, 8'd12},      // R12
    '{1'b0, 12'h07C, 32'h0, 32'h1234_5678, 8'd12},      // R12
    '{1'b1, 12'h05C, 32'h4, 32'h0, 8'd7},               // trigger
    '{1'b0, 12'h050, 32'h0, 32'h81, 8'd10},             // R10 acked
    '{1'b0, 12'h04C, 32'h0, 32'h10, 8'd8},              // R8 status
    '{1'b1, 12'h058, 32'h10, 32'h0, 8'd9},
    '{1'b0, 12'h04C, 32'h0, 32'h0, 8'd9},               // R9
    '{1'b1, 12'h040, 32'h4, 32'h0, 8'd5},               // release
    '{1'b0, 12'h050, 32'h0, 32'h11, 8'd5},              // R5 idle
    '{1'b0, 12'h040, 32'h0, 32'h0, 8'd5}                // R5 unowned
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mbox_ctrl i_mbox_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 irq after reset", irq_o, 32'h0);
    bus_rd(12'h7D0, r); chk("R1 ch31 state", r, 32'h10);
    bus_rd(12'h7D4, r); chk("R1 ch31 mask", r, 32'hFFFF_FFFF);

    for (int i = 0; i < 25; i++) begin
      if (TBL[i].wr) bus_wr(TBL[i].addr, TBL[i].data);
      else begin
        bus_rd(TBL[i].addr, r);
        chk($sformatf("R%0d table %0d", TBL[i].req, i), r, TBL[i].exp);
      end
    end

    // manual mode on channel 31 (0x7C0)
    bus_wr(12'h7C0, 32'h1);
    bus_wr(12'h7C4, 32'h2);
    bus_wr(12'h7D4, 32'hFFFF_FFFD);
    bus_wr(12'h7DC, 32'h1);
    chk("R8 irq line raised", irq_o, 32'h2);
    bus_rd(12'h7D0, r); chk("R11 manual still busy", r, 32'h0);
    bus_wr(12'h7C0, 32'h1);
    bus_rd(12'h7C0, r); chk("R5 no release while busy", r, 32'h1);
    bus_wr(12'h7C8, 32'h2);
    bus_rd(12'h7D0, r); chk("R11 acked after target clear", r, 32'h80);
    bus_rd(12'h7C4, r); chk("R11 target bits cleared", r, 32'h0);
    bus_wr(12'h7D4, 32'hFFFF_FFFF);
    chk("R8 masked line quiet", irq_o, 32'h0);
    bus_rd(12'h7CC, r); chk("R8 masked status", r, 32'h0);
    bus_rd(12'h7DC, r); chk("R3 trigger reads zero", r, 32'h0);

    // channel 2 (0x80): bad claim and unowned trigger
    bus_wr(12'h080, 32'h3);
    bus_rd(12'h080, r); chk("R4 non-one-hot claim", r, 32'h0);
    bus_wr(12'h084, 32'h1);
    bus_wr(12'h09C, 32'h1);
    bus_rd(12'h090, r); chk("R7 unowned trigger ignored", r, 32'h10);
    chk("R7 no irq from unowned trigger", irq_o, 32'h0);
    bus_rd(12'h900, r); chk("R12 unmapped reads zero", r, 32'h0);

    // relock with a wrong key
    bus_wr(12'hA00, 32'h0);
    bus_rd(12'hA00, r); chk("R2 relocked", r, 32'h1);
    bus_wr(12'h084, 32'h55);
    bus_rd(12'h084, r); chk("R2 locked target write", r, 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule